// File: doc/BRIEF.md
# Indexed-Colour Display Controller Register File

This block is the control-register front end of an indexed-colour display engine. A processor reaches it through a simple 32-bit memory-mapped port. Each request carries a valid strobe, a write flag, a 2-bit size code, a 21-bit byte address and write data. The port has no ready signal: a request is accepted in the cycle it is presented, and read data appears on the response bus in the following cycle.

The block holds the screen geometry, the control word, the screen start offset and the cursor position. It also holds three lookup tables: a 256-entry colour palette, a 3-entry cursor palette and a 512-word cursor pattern store. The decoded fields and three combinational lookup ports go to the pixel pipeline.

Byte and halfword writes are merged into the current 32-bit read value of the addressed register before they are stored. The block drives an interrupt line, a one-cycle soft-reset pulse and a one-cycle invalidate pulse. The invalidate pulse tells the pixel pipeline that its cached view of the frame is stale.

Top module: `dcr_regfile`

## Requirements
- R1: A word read at offset 0x000000 returns 0x00000010, and writes to that offset change nothing.
- R2: A write to the horizontal register (offset 0x080118) stores width = value×4, truncated to 32 bits, and a read returns width/4. A write to the vertical register (offset 0x080150) stores height = value/2, and a read returns height×2.
- R3: The control word (offset 0x080300) reads back as written. Bit 10 drives blank_o and bit 23 drives cursor_off_o. Bits 22:20 give depth_o, where codes 0..7 map to 1, 2, 4, 8, 15, 16, 0 and 0 bits per pixel.
- R4: Colour palette entry i sits at 0x080800+8i and cursor palette entry i sits at 0x080508+8i. Each entry packs red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Cursor palette reads return the entry, and colour palette reads return 0. pix_rgb_o shows the colour entry selected by pix_index_i. cur_rgb_o shows cursor entry cur_sel_i−1, or 0 when cur_sel_i is 0.
- R5: Cursor pattern word i (16 bits) sits at 0x081000+8i for i in 0..511. Writes keep bits 15:0, reads return the word zero-extended, and pat_word_o shows the word selected by pat_addr_i.
- R6: The cursor position (offset 0x080638) gives cursor_x_o from bits 31:12 and cursor_y_o from bits 11:0. The screen start (offset 0x080400) drives screen_start_o. Both registers are write-only and read as 0.
- R7: Size code 0 is a byte access and selects lane addr[1:0], with lane 0 as bits 7:0. Size code 1 is a halfword access and selects the upper half when addr[1] is 1. Codes 2 and 3 are word accesses. Narrow read data is returned right-aligned.
- R8: A byte or halfword write takes its data from the low bits of the write bus and replaces only the selected lane of the register's current read value. The merged word is then stored as a word write, so write-only registers merge with 0.
- R9: Writes to the boot register (0x080000), the timing registers (0x080108–0x080170 except 0x080118 and 0x080150) and the cycle-mask register (0x080200) change no state.
- R10: A write to offset 0x180000 clears all tables, the control word, the position, the screen start, the width and the height. It also raises soft_rst_o for exactly the next cycle.
- R11: irq_o rises after a cycle with frame_done_i high and stays high until a write is accepted. Any accepted write, to any address, lowers it, and a write takes priority over frame_done_i in the same cycle.
- R12: inval_o is high for the one cycle after a write to the control word, the screen start, either palette, the pattern store or the reset register. It stays low after writes elsewhere.
- R13: Read data appears on rsp_rdata_o in the cycle after the request. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr_i | input | 21 | Byte address |
| req_wdata_i | input | 32 | Write data, narrow data in the low bits |
| rsp_rdata_o | output | 32 | Read data, one cycle after the request |
| frame_done_i | input | 1 | Frame refresh completed |
| irq_o | output | 1 | Frame interrupt |
| soft_rst_o | output | 1 | One-cycle pulse after a reset-register write |
| inval_o | output | 1 | One-cycle display invalidate pulse |
| blank_o | output | 1 | Forced blanking |
| cursor_off_o | output | 1 | Cursor disabled |
| depth_o | output | 5 | Decoded bits per pixel |
| screen_start_o | output | 32 | Screen start offset |
| width_o | output | 32 | Active width in pixels |
| height_o | output | 32 | Active height in lines |
| cursor_x_o | output | 20 | Cursor X coordinate |
| cursor_y_o | output | 12 | Cursor Y coordinate |
| pix_index_i | input | 8 | Colour palette lookup index |
| pix_rgb_o | output | 24 | Colour palette lookup result |
| cur_sel_i | input | 2 | Cursor colour selector (0 transparent) |
| cur_rgb_o | output | 24 | Cursor palette lookup result |
| pat_addr_i | input | 9 | Cursor pattern lookup index |
| pat_word_o | output | 16 | Cursor pattern lookup result |

## Verification
The hardest situation to reach from the ports is a narrow write whose merge source differs from the stored state. Examples are a halfword write to a pattern word, where the upper half must vanish, a byte write to the write-only screen start, which must lose its old upper bytes, and a halfword write to the horizontal register, which merges in the divided-down value. The stimulus first loads these registers with full words chosen so that the merged and unmerged results differ. It then issues the narrow write and observes the exported fields and the read-back values. The same-cycle collision of frame_done_i with a write is produced by driving both in one cycle.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  localparam int AW = 21;

  localparam logic [AW-1:0] OFS_ID    = 21'h000000;
  localparam logic [AW-1:0] OFS_HDISP = 21'h080118;
  localparam logic [AW-1:0] OFS_VDISP = 21'h080150;
  localparam logic [AW-1:0] OFS_CTRL  = 21'h080300;
  localparam logic [AW-1:0] OFS_START = 21'h080400;
  localparam logic [AW-1:0] OFS_CPAL  = 21'h080508;
  localparam logic [AW-1:0] OFS_CPOS  = 21'h080638;
  localparam logic [AW-1:0] OFS_PAL   = 21'h080800;
  localparam logic [AW-1:0] OFS_PAT   = 21'h081000;
  localparam logic [AW-1:0] OFS_RESET = 21'h180000;

  localparam logic [31:0] ID_VALUE = 32'h0000_0010;

  localparam int CTL_BLANK_BIT = 10;
  localparam int CTL_NOCUR_BIT = 23;
  localparam int CTL_DEPTH_LSB = 20;

  typedef enum logic [3:0] {
    RK_NONE, RK_ID, RK_HDISP, RK_VDISP, RK_CTRL, RK_START,
    RK_CPOS, RK_CPAL, RK_PAL, RK_PAT, RK_RESET
  } reg_kind_e;

  function automatic logic [4:0] depth_of(input logic [2:0] code);
    case (code)
      3'd0:    depth_of = 5'd1;
      3'd1:    depth_of = 5'd2;
      3'd2:    depth_of = 5'd4;
      3'd3:    depth_of = 5'd8;
      3'd4:    depth_of = 5'd15;
      3'd5:    depth_of = 5'd16;
      default: depth_of = 5'd0;
    endcase
  endfunction

  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] wd,
                                             input logic [1:0]  size,
                                             input logic [1:0]  lane);
    logic [31:0] r;
    r = old_w;
    case (size)
      2'd0: r[lane*8 +: 8] = wd[7:0];
      2'd1: r[lane[1]*16 +: 16] = wd[15:0];
      default: r = wd;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] lane_extract(input logic [31:0] w,
                                               input logic [1:0]  size,
                                               input logic [1:0]  lane);
    case (size)
      2'd0:    lane_extract = {24'h0, w[lane*8 +: 8]};
      2'd1:    lane_extract = {16'h0, w[lane[1]*16 +: 16]};
      default: lane_extract = w;
    endcase
  endfunction

endpackage

// File: rtl/dcr_decode.sv
module dcr_decode
  import dcr_pkg::*;
#(
  parameter int CPAL_N = 3,
  parameter int PAL_N  = 256,
  parameter int PAT_N  = 512,
  parameter int IDX_W  = 9
) (
  input  logic [AW-1:0]    addr_i,
  output reg_kind_e        kind_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [AW-1:0] CPAL_SPAN = AW'(CPAL_N * 8);
  localparam logic [AW-1:0] PAL_SPAN  = AW'(PAL_N * 8);
  localparam logic [AW-1:0] PAT_SPAN  = AW'(PAT_N * 8);

  logic [AW-1:0] waddr;
  logic [AW-1:0] off;

  always_comb begin
    waddr  = {addr_i[AW-1:2], 2'b00};
    off    = '0;
    kind_o = RK_NONE;
    if (waddr >= OFS_PAT && waddr < OFS_PAT + PAT_SPAN) begin
      kind_o = RK_PAT;
      off    = waddr - OFS_PAT;
    end else if (waddr >= OFS_PAL && waddr < OFS_PAL + PAL_SPAN) begin
      kind_o = RK_PAL;
      off    = waddr - OFS_PAL;
    end else if (waddr >= OFS_CPAL && waddr < OFS_CPAL + CPAL_SPAN) begin
      kind_o = RK_CPAL;
      off    = waddr - OFS_CPAL;
    end else begin
      case (waddr)
        OFS_ID:    kind_o = RK_ID;
        OFS_HDISP: kind_o = RK_HDISP;
        OFS_VDISP: kind_o = RK_VDISP;
        OFS_CTRL:  kind_o = RK_CTRL;
        OFS_START: kind_o = RK_START;
        OFS_CPOS:  kind_o = RK_CPOS;
        OFS_RESET: kind_o = RK_RESET;
        default:   kind_o = RK_NONE;
      endcase
    end
    idx_o = off[IDX_W+2:3];
  end
endmodule

// File: rtl/dcr_table.sv
module dcr_table #(
  parameter int N  = 256,
  parameter int W  = 24,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [W-1:0]  wdat_i,
  input  logic [IW-1:0] ridx_a_i,
  output logic [W-1:0]  rdat_a_o,
  input  logic [IW-1:0] ridx_b_i,
  output logic [W-1:0]  rdat_b_o
);
  logic [W-1:0] mem [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           mem[g] <= '0;
      else if (clr_i)                       mem[g] <= '0;
      else if (we_i && widx_i == IW'(g))    mem[g] <= wdat_i;
    end
  end

  assign rdat_a_o = (32'(ridx_a_i) < N) ? mem[ridx_a_i] : '0;
  assign rdat_b_o = (32'(ridx_b_i) < N) ? mem[ridx_b_i] : '0;

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (rdat_a_o == '0 && rdat_b_o == '0)); // R10
endmodule

// File: rtl/dcr_regfile.sv
module dcr_regfile
  import dcr_pkg::*;
#(
  parameter int PAL_N  = 256,
  parameter int CPAL_N = 3,
  parameter int PAT_N  = 512,
  parameter int PAT_W  = 16,
  parameter int RGB_W  = 24,
  parameter int XW     = 20,
  parameter int YW     = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid_i,
  input  logic                      req_write_i,
  input  logic [1:0]                req_size_i,
  input  logic [20:0]               req_addr_i,
  input  logic [31:0]               req_wdata_i,
  output logic [31:0]               rsp_rdata_o,
  input  logic                      frame_done_i,
  output logic                      irq_o,
  output logic                      soft_rst_o,
  output logic                      inval_o,
  output logic                      blank_o,
  output logic                      cursor_off_o,
  output logic [4:0]                depth_o,
  output logic [31:0]               screen_start_o,
  output logic [31:0]               width_o,
  output logic [31:0]               height_o,
  output logic [XW-1:0]             cursor_x_o,
  output logic [YW-1:0]             cursor_y_o,
  input  logic [$clog2(PAL_N)-1:0]  pix_index_i,
  output logic [RGB_W-1:0]          pix_rgb_o,
  input  logic [1:0]                cur_sel_i,
  output logic [RGB_W-1:0]          cur_rgb_o,
  input  logic [$clog2(PAT_N)-1:0]  pat_addr_i,
  output logic [PAT_W-1:0]          pat_word_o
);
  localparam int PAL_IW  = $clog2(PAL_N);
  localparam int CPAL_IW = (CPAL_N > 1) ? $clog2(CPAL_N) : 1;
  localparam int PAT_IW  = $clog2(PAT_N);
  localparam int IDX_W   = (PAT_IW > PAL_IW) ? PAT_IW : PAL_IW;

  // decoded request
  reg_kind_e        kind;
  logic [IDX_W-1:0] idx;
  logic             wr_fire, rd_fire, clr_all, touch_vis;
  logic [31:0]      cur_word, merged_word;

  // state
  logic [31:0] ctrl_q, start_q, width_q, height_q, cpos_q, rdata_q;
  logic        irq_q, soft_q, inval_q;

  logic [RGB_W-1:0] cpal_bus, pal_bus_unused;
  logic [PAT_W-1:0] pat_bus;

  dcr_decode #(.CPAL_N(CPAL_N), .PAL_N(PAL_N), .PAT_N(PAT_N), .IDX_W(IDX_W)) u_dec (
    .addr_i (req_addr_i),
    .kind_o (kind),
    .idx_o  (idx)
  );

  assign wr_fire   = req_valid_i && req_write_i;
  assign rd_fire   = req_valid_i && !req_write_i;
  assign clr_all   = wr_fire && kind == RK_RESET;
  assign touch_vis = wr_fire && (kind == RK_CTRL || kind == RK_START || kind == RK_CPAL ||
                                 kind == RK_PAL  || kind == RK_PAT   || kind == RK_RESET);

  dcr_table #(.N(PAL_N), .W(RGB_W), .IW(PAL_IW)) u_pal (
    .clk, .rst_n,
    .clr_i    (clr_all),
    .we_i     (wr_fire && kind == RK_PAL),
    .widx_i   (idx[PAL_IW-1:0]),
    .wdat_i   (merged_word[RGB_W-1:0]),
    .ridx_a_i (idx[PAL_IW-1:0]),
    .rdat_a_o (pal_bus_unused),
    .ridx_b_i (pix_index_i),
    .rdat_b_o (pix_rgb_o)
  );

  dcr_table #(.N(CPAL_N), .W(RGB_W), .IW(CPAL_IW)) u_cpal (
    .clk, .rst_n,
    .clr_i    (clr_all),
    .we_i     (wr_fire && kind == RK_CPAL),
    .widx_i   (idx[CPAL_IW-1:0]),
    .wdat_i   (merged_word[RGB_W-1:0]),
    .ridx_a_i (idx[CPAL_IW-1:0]),
    .rdat_a_o (cpal_bus),
    .ridx_b_i (CPAL_IW'(cur_sel_i - 2'd1)),
    .rdat_b_o (cur_rgb_o)
  );

  dcr_table #(.N(PAT_N), .W(PAT_W), .IW(PAT_IW)) u_pat (
    .clk, .rst_n,
    .clr_i    (clr_all),
    .we_i     (wr_fire && kind == RK_PAT),
    .widx_i   (idx[PAT_IW-1:0]),
    .wdat_i   (merged_word[PAT_W-1:0]),
    .ridx_a_i (idx[PAT_IW-1:0]),
    .rdat_a_o (pat_bus),
    .ridx_b_i (pat_addr_i),
    .rdat_b_o (pat_word_o)
  );

  // read view of the addressed register; also the merge source for narrow writes
  always_comb begin
    case (kind)
      RK_ID:    cur_word = ID_VALUE;
      RK_HDISP: cur_word = width_q >> 2;
      RK_VDISP: cur_word = height_q << 1;
      RK_CTRL:  cur_word = ctrl_q;
      RK_CPAL:  cur_word = 32'(cpal_bus);
      RK_PAT:   cur_word = 32'(pat_bus);
      default:  cur_word = 32'h0;
    endcase
  end

  assign merged_word = lane_merge(cur_word, req_wdata_i, req_size_i, req_addr_i[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      start_q  <= '0;
      width_q  <= '0;
      height_q <= '0;
      cpos_q   <= '0;
    end else if (clr_all) begin
      ctrl_q   <= '0;
      start_q  <= '0;
      width_q  <= '0;
      height_q <= '0;
      cpos_q   <= '0;
    end else if (wr_fire) begin
      case (kind)
        RK_HDISP: width_q  <= merged_word << 2;
        RK_VDISP: height_q <= merged_word >> 1;
        RK_CTRL:  ctrl_q   <= merged_word;
        RK_START: start_q  <= merged_word;
        RK_CPOS:  cpos_q   <= merged_word;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
      soft_q  <= 1'b0;
      inval_q <= 1'b0;
    end else begin
      if (rd_fire) rdata_q <= lane_extract(cur_word, req_size_i, req_addr_i[1:0]);
      if (wr_fire)           irq_q <= 1'b0;
      else if (frame_done_i) irq_q <= 1'b1;
      soft_q  <= clr_all;
      inval_q <= touch_vis;
    end
  end

  assign rsp_rdata_o    = rdata_q;
  assign irq_o          = irq_q;
  assign soft_rst_o     = soft_q;
  assign inval_o        = inval_q;
  assign blank_o        = ctrl_q[CTL_BLANK_BIT];
  assign cursor_off_o   = ctrl_q[CTL_NOCUR_BIT];
  assign depth_o        = depth_of(ctrl_q[CTL_DEPTH_LSB +: 3]);
  assign screen_start_o = start_q;
  assign width_o        = width_q;
  assign height_o       = height_q;
  assign cursor_x_o     = cpos_q[YW +: XW];
  assign cursor_y_o     = cpos_q[YW-1:0];

  AST_ID_CONSTANT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && req_addr_i == OFS_ID && req_size_i[1]) |=> rsp_rdata_o == ID_VALUE); // R1
  AST_DEPTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o inside {5'd0, 5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16}); // R3
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (width_o == 0 && height_o == 0 && screen_start_o == 0 && !blank_o)); // R10
  AST_IRQ_WRITE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !irq_o); // R11
  AST_IRQ_FRAME_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done_i && !wr_fire) |=> irq_o); // R11
  AST_INVAL_ON_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && kind == RK_CTRL) |=> inval_o); // R12
  AST_READ_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rsp_rdata_o)); // R13
endmodule

// File: tb/sim_dcr_regfile.sv
`timescale 1ns/1ps
module sim_dcr_regfile;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0, frame_done = 0;
  logic [1:0]  req_size = 2;
  logic [20:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [31:0] rsp_rdata, screen_start, width, height;
  logic        irq, soft_rst, inval, blank, cursor_off;
  logic [4:0]  depth;
  logic [19:0] cursor_x;
  logic [11:0] cursor_y;
  logic [7:0]  pix_index = 0;
  logic [23:0] pix_rgb, cur_rgb;
  logic [1:0]  cur_sel = 0;
  logic [8:0]  pat_addr = 0;
  logic [15:0] pat_word;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  dcr_regfile u0 (
    .clk, .rst_n,
    .req_valid_i(req_valid), .req_write_i(req_write), .req_size_i(req_size),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rsp_rdata_o(rsp_rdata),
    .frame_done_i(frame_done), .irq_o(irq), .soft_rst_o(soft_rst), .inval_o(inval),
    .blank_o(blank), .cursor_off_o(cursor_off), .depth_o(depth),
    .screen_start_o(screen_start), .width_o(width), .height_o(height),
    .cursor_x_o(cursor_x), .cursor_y_o(cursor_y),
    .pix_index_i(pix_index), .pix_rgb_o(pix_rgb),
    .cur_sel_i(cur_sel), .cur_rgb_o(cur_rgb),
    .pat_addr_i(pat_addr), .pat_word_o(pat_word)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [20:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [20:0] a, input logic [1:0] sz, input logic [31:0] e,
                    input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_size = sz; req_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: a read accepted at a rising edge is compared at the next falling edge
  always @(posedge clk) rd_seen <= req_valid && !req_write;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk("R13 unexpected read data", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  function automatic logic [4:0] bpp_of(input int code);
    logic [4:0] t [8] = '{5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16, 5'd0, 5'd0};
    return t[code];
  endfunction

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1;
    idle(1);
    chk("R11 reset irq", 32'(irq), 0);
    chk("R3 reset depth", 32'(depth), 1);
    chk("R2 reset width", width, 0);
    chk("R12 reset inval", 32'(inval), 0);

    // R1
    rd(21'h000000, 2, 32'h10, "R1 id read");
    wr(21'h000000, 2, 32'hFFFF_FFFF);
    rd(21'h000000, 2, 32'h10, "R1 id after write");

    // R2
    v = 32'h140;
    wr(21'h080118, 2, v);
    chk("R2 width", width, v * 4);
    chk("R12 no inval on hdisp", 32'(inval), 0);
    rd(21'h080118, 2, v, "R2 hdisp read");
    wr(21'h080118, 2, 32'hFFFF_FFFF);
    chk("R2 width wrap", width, 32'hFFFF_FFFC);
    rd(21'h080118, 2, 32'h3FFF_FFFF, "R2 hdisp wrap read");
    wr(21'h080118, 2, 32'h140);
    wr(21'h080150, 2, 32'h1E1);
    chk("R2 height", height, 32'h1E1 / 2);
    rd(21'h080150, 2, 32'h1E0, "R2 vdisp read");

    // R3, R12
    wr(21'h080300, 2, 32'h00B0_0400);
    chk("R12 inval after ctrl", 32'(inval), 1);
    chk("R3 blank", 32'(blank), 1);
    chk("R3 cursor off", 32'(cursor_off), 1);
    chk("R3 depth 8", 32'(depth), 8);
    idle(1);
    chk("R12 inval one cycle", 32'(inval), 0);
    rd(21'h080300, 2, 32'h00B0_0400, "R3 ctrl read");
    for (int c = 0; c < 8; c++) begin
      wr(21'h080300, 2, 32'(c) << 20);
      chk($sformatf("R3 depth code %0d", c), 32'(depth), 32'(bpp_of(c)));
    end
    wr(21'h080300, 2, 32'h00B0_0400);

    // R7
    rd(21'h080302, 0, 32'hB0, "R7 byte lane2");
    rd(21'h080301, 0, 32'h04, "R7 byte lane1");
    rd(21'h080303, 0, 32'h00, "R7 byte lane3");
    rd(21'h080302, 1, 32'h00B0, "R7 half upper");
    rd(21'h080300, 1, 32'h0400, "R7 half lower");

    // R8
    wr(21'h080300, 0, 32'hFFFF_FF55);
    rd(21'h080300, 2, 32'h00B0_0455, "R8 byte merge ctrl");
    wr(21'h08011A, 1, 32'h0000_0001);
    chk("R8 half merge width", width, 32'h0001_0140 * 4);
    rd(21'h080118, 2, 32'h0001_0140, "R8 hdisp after merge");

    // R6
    wr(21'h080400, 2, 32'hFFFF_0000);
    chk("R6 screen start", screen_start, 32'hFFFF_0000);
    rd(21'h080400, 2, 32'h0, "R6 start reads zero");
    wr(21'h080401, 0, 32'h12);
    chk("R8 write-only merge", screen_start, 32'h0000_1200);
    wr(21'h080638, 2, 32'h0006_4123);
    chk("R6 cursor x", 32'(cursor_x), 32'h64);
    chk("R6 cursor y", 32'(cursor_y), 32'h123);
    rd(21'h080638, 2, 32'h0, "R6 cpos reads zero");

    // R4
    wr(21'h080828, 2, 32'hFF12_3456);
    chk("R12 inval after palette", 32'(inval), 1);
    pix_index = 5; #1;
    chk("R4 palette entry 5", 32'(pix_rgb), 32'h12_3456);
    pix_index = 4; #1;
    chk("R4 palette entry 4 untouched", 32'(pix_rgb), 0);
    rd(21'h080828, 2, 32'h0, "R4 palette reads zero");
    wr(21'h080FF8, 2, 32'h00AB_CDEF);
    pix_index = 255; #1;
    chk("R4 palette entry 255", 32'(pix_rgb), 32'hAB_CDEF);
    wr(21'h080518, 2, 32'h00AB_CDEF);
    wr(21'h080508, 2, 32'h0001_0203);
    rd(21'h080518, 2, 32'h00AB_CDEF, "R4 cursor palette read");
    cur_sel = 3; #1;
    chk("R4 cursor colour 3", 32'(cur_rgb), 32'hAB_CDEF);
    cur_sel = 1; #1;
    chk("R4 cursor colour 1", 32'(cur_rgb), 32'h01_0203);
    cur_sel = 0; #1;
    chk("R4 cursor transparent", 32'(cur_rgb), 0);

    // R5
    wr(21'h081FF8, 2, 32'hDEAD_BEEF);
    rd(21'h081FF8, 2, 32'h0000_BEEF, "R5 pattern read");
    pat_addr = 511; #1;
    chk("R5 pattern lookup", 32'(pat_word), 32'hBEEF);
    wr(21'h081FFA, 1, 32'h1234);
    chk("R8 half write drops upper", 32'(pat_word), 32'hBEEF);
    wr(21'h081001, 0, 32'h7A);
    pat_addr = 0; #1;
    chk("R5 pattern byte lane1", 32'(pat_word), 32'h7A00);

    // R11, R9
    @(negedge clk); frame_done = 1; @(negedge clk); frame_done = 0;
    chk("R11 irq after frame", 32'(irq), 1);
    idle(2);
    chk("R11 irq holds", 32'(irq), 1);
    wr(21'h080108, 2, 32'hFFFF_FFFF);
    chk("R11 irq cleared by timing write", 32'(irq), 0);
    wr(21'h080200, 2, 32'hFFFF_FFFF);
    wr(21'h080000, 2, 32'hFFFF_FFFF);
    wr(21'h080170, 2, 32'hFFFF_FFFF);
    chk("R9 width kept", width, 32'h0001_0140 * 4);
    chk("R9 start kept", screen_start, 32'h0000_1200);
    rd(21'h080300, 2, 32'h00B0_0455, "R9 ctrl kept");
    @(negedge clk);
    frame_done = 1; req_valid = 1; req_write = 1; req_size = 2;
    req_addr = 21'h080004; req_wdata = 0;
    @(negedge clk);
    frame_done = 0; req_valid = 0; req_write = 0;
    chk("R11 write beats frame", 32'(irq), 0);

    // R13
    rd(21'h080004, 2, 32'h0, "R13 unmapped read");
    rd(21'h1FFFFC, 2, 32'h0, "R13 top unmapped read");

    // R10
    wr(21'h180000, 2, 32'h0);
    chk("R10 soft reset pulse", 32'(soft_rst), 1);
    chk("R12 inval on reset", 32'(inval), 1);
    idle(1);
    chk("R10 pulse one cycle", 32'(soft_rst), 0);
    chk("R10 width cleared", width, 0);
    chk("R10 height cleared", height, 0);
    chk("R10 start cleared", screen_start, 0);
    chk("R10 cursor cleared", 32'(cursor_x), 0);
    pix_index = 5; cur_sel = 3; pat_addr = 511; #1;
    chk("R10 palette cleared", 32'(pix_rgb), 0);
    chk("R10 cursor palette cleared", 32'(cur_rgb), 0);
    chk("R10 pattern cleared", 32'(pat_word), 0);
    rd(21'h080300, 2, 32'h0, "R10 ctrl cleared");

    idle(3);
    if (exp_q.size() != 0) chk("R13 reads outstanding", 32'(exp_q.size()), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule